// File: doc/BRIEF.md
# Bus Port Quiesce Handshake Controller

This controller brings a single bus master port to rest before the port loses power. A one-cycle start pulse begins the sequence. If the port already reports idle, the controller finishes straight away and never raises a halt request. Otherwise it raises a halt request and waits for the port to acknowledge. The wait is bounded by a timeout measured in milliseconds, and a parameter converts it to clock cycles. When the wait ends, whether by acknowledge or by timeout, the controller samples idle once more and lowers the request. If the port is still not idle at that point, it sets a failure flag.

A timeout is not an error by itself. Only a port that is still busy after the wait counts as a failure. The acknowledge and idle inputs come from another clock domain, so each passes through a two-stage synchronizer before the controller uses it. Acknowledge is examined on every cycle. The millisecond scale only sets the timeout length. Once the request is released, the port is expected to stay halted until it is reset.

Top module: `port_quiesce_ctrl`

## Requirements
- R1: After synchronous reset, halt_req_o, done_o and failed_o are all low and the controller accepts a start.
- R2: halt_ack_i and idle_i each pass through two flip-flops before the controller uses them. A change on either input can affect the outputs no earlier than the third rising edge after the change.
- R3: A start accepted while synchronized idle is high makes done_o pulse high on the next cycle and clears failed_o. halt_req_o stays low throughout.
- R4: A start accepted while synchronized idle is low raises halt_req_o at the next edge and clears failed_o. halt_req_o then stays high until the wait ends.
- R5: The wait ends on the first cycle in which synchronized acknowledge is high. Without an acknowledge, it ends after CYCLES_PER_MS*TIMEOUT_MS cycles in the waiting state.
- R6: One edge after the wait ends, halt_req_o falls and done_o is high for exactly that one cycle. failed_o is set to the inverse of synchronized idle at that point.
- R7: A timeout with synchronized idle high at the end of the wait leaves failed_o low.
- R8: failed_o holds its value until the next accepted start.
- R9: A start that arrives while a handshake is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to quiesce the port |
| halt_ack_i | input | 1 | Halt acknowledge from the port (asynchronous) |
| idle_i | input | 1 | Port idle status (asynchronous) |
| halt_req_o | output | 1 | Halt request to the port |
| done_o | output | 1 | One-cycle pulse when the sequence finishes |
| failed_o | output | 1 | Port was not idle when the sequence finished |

## Verification
The hardest case to reach is a full timeout that ends with the port idle. Here idle must rise during the wait while acknowledge stays low, so the only thing that ends the wait is the cycle count. The bench shrinks the millisecond scale to a few cycles so that a timeout is short. It raises idle midway through the wait and checks that the request lasts exactly the bounded number of cycles, with failed_o staying low. A reference model tracks both synchronizer stages and the elapsed wait on every clock, so one-cycle errors in the acknowledge latency or the timeout boundary appear as mismatches.

// File: rtl/pq_pkg.sv
package pq_pkg;
    typedef enum logic [1:0] {
        PQ_READY = 2'd0,
        PQ_WAIT  = 2'd1,
        PQ_CHECK = 2'd2
    } pq_state_e;

    typedef struct packed {
        logic req;
        logic done;
        logic failed;
    } pq_out_t;

    localparam pq_out_t PQ_OUT_RESET = '{req: 1'b0, done: 1'b0, failed: 1'b0};

    function automatic int pq_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/pq_sync.sv
module pq_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], d_i[b]};
        end
        assign q_o[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/pq_wait_timer.sv
module pq_wait_timer
    import pq_pkg::*;
#(
    parameter int CYCLES_PER_MS = 50000,
    parameter int TIMEOUT_MS    = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic expired_o
);
    localparam int PRE_W = pq_width(CYCLES_PER_MS);
    localparam int MS_W  = pq_width(TIMEOUT_MS + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYCLES_PER_MS - 1);
    localparam logic [MS_W-1:0]  MS_LIMIT = MS_W'(TIMEOUT_MS);

    logic [PRE_W-1:0] pre_q;
    logic [MS_W-1:0]  ms_q;

    assign expired_o = (ms_q == MS_LIMIT);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (!expired_o) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                ms_q  <= ms_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assert_ms_bounded_R5: assert property (@(posedge clk) disable iff (rst)
        ms_q <= MS_LIMIT);
    assert_stops_at_limit_R5: assert property (@(posedge clk) disable iff (rst)
        (run_i && expired_o) |=> (!run_i || expired_o));
endmodule

// File: rtl/pq_fsm.sv
module pq_fsm
    import pq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start_i,
    input  logic    ack_s_i,
    input  logic    idle_s_i,
    input  logic    expired_i,
    output logic    run_o,
    output pq_out_t out_o
);
    pq_state_e state_q, state_d;
    pq_out_t   out_q, out_d;

    always_comb begin
        state_d     = state_q;
        out_d       = out_q;
        out_d.done  = 1'b0;
        unique case (state_q)
            PQ_READY: begin
                if (start_i) begin
                    out_d.failed = 1'b0;
                    if (idle_s_i) begin
                        out_d.done = 1'b1;
                    end else begin
                        out_d.req = 1'b1;
                        state_d   = PQ_WAIT;
                    end
                end
            end
            PQ_WAIT: begin
                if (ack_s_i || expired_i) state_d = PQ_CHECK;
            end
            PQ_CHECK: begin
                out_d.req    = 1'b0;
                out_d.done   = 1'b1;
                out_d.failed = !idle_s_i;
                state_d      = PQ_READY;
            end
            default: state_d = PQ_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PQ_READY;
            out_q   <= PQ_OUT_RESET;
        end else begin
            state_q <= state_d;
            out_q   <= out_d;
        end
    end

    assign run_o = (state_q == PQ_WAIT);
    assign out_o = out_q;

    assert_skip_no_req_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == PQ_READY && start_i && idle_s_i) |=> (out_q.done && !out_q.req));
    assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == PQ_WAIT && !ack_s_i && !expired_i) |=> (state_q == PQ_WAIT && out_q.req));
endmodule

// File: rtl/port_quiesce_ctrl.sv
module port_quiesce_ctrl
    import pq_pkg::*;
#(
    parameter int CYCLES_PER_MS = 50000,
    parameter int TIMEOUT_MS    = 100,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic halt_ack_i,
    input  logic idle_i,
    output logic halt_req_o,
    output logic done_o,
    output logic failed_o
);
    logic [1:0] raw_in, synced;
    logic       run, expired;
    pq_out_t    fsm_out;

    assign raw_in = {halt_ack_i, idle_i};

    pq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_in),
        .q_o (synced)
    );

    pq_wait_timer #(.CYCLES_PER_MS(CYCLES_PER_MS), .TIMEOUT_MS(TIMEOUT_MS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run_i     (run),
        .expired_o (expired)
    );

    pq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .ack_s_i   (synced[1]),
        .idle_s_i  (synced[0]),
        .expired_i (expired),
        .run_o     (run),
        .out_o     (fsm_out)
    );

    assign halt_req_o = fsm_out.req;
    assign done_o     = fsm_out.done;
    assign failed_o   = fsm_out.failed;

    assert_req_falls_with_done_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(halt_req_o) |-> done_o);
    assert_req_rises_after_start_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(halt_req_o) |-> $past(start_i));
    assert_failed_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(start_i) && !done_o) |-> $stable(failed_o));
    assert_done_ends_req_R6: assert property (@(posedge clk) disable iff (rst)
        (done_o && $past(halt_req_o)) |-> !halt_req_o);
endmodule

// File: tb/port_quiesce_ctrl_bench.sv
module port_quiesce_ctrl_bench;
    localparam int CPM   = 4;
    localparam int TOUT  = 5;
    localparam int LIMIT = CPM * TOUT;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, ack = 1'b0, idle = 1'b0;
    logic req, done, failed;

    int checks = 0, fails = 0, cycles = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    port_quiesce_ctrl #(.CYCLES_PER_MS(CPM), .TIMEOUT_MS(TOUT)) u_port_quiesce_ctrl (
        .clk (clk), .rst (rst), .start_i (start), .halt_ack_i (ack), .idle_i (idle),
        .halt_req_o (req), .done_o (done), .failed_o (failed)
    );

    // behavioural reference
    int  m_state = 0;           // 0 ready, 1 waiting, 2 final check
    int  m_elapsed = 0;
    bit  m_req = 0, m_done = 0, m_failed = 0;
    bit  ack_hist[$], idle_hist[$];

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_state = 0; m_req = 0; m_done = 0; m_failed = 0; m_elapsed = 0;
            ack_hist = '{0, 0}; idle_hist = '{0, 0};
        end else begin
            bit a_s, i_s;
            a_s = ack_hist[0];
            i_s = idle_hist[0];
            void'(ack_hist.pop_front());
            void'(idle_hist.pop_front());
            ack_hist.push_back(ack);
            idle_hist.push_back(idle);
            m_done = 0;
            case (m_state)
                0: if (start) begin
                       m_failed = 0;
                       if (i_s) m_done = 1;
                       else begin m_req = 1; m_state = 1; m_elapsed = 0; end
                   end
                1: if (a_s || m_elapsed >= LIMIT) m_state = 2;
                   else m_elapsed++;
                default: begin
                       m_failed = !i_s; m_req = 0; m_done = 1; m_state = 0;
                   end
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R4/R5 halt_req model", req, m_req);
            check("R6 done model", done, m_done);
            check("R8 failed model", failed, m_failed);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1; tick(1); start = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : stim
        int high_cnt;
        tick(3);
        rst = 1'b0;
        tick(1);
        check("R1 reset halt_req", req, 1'b0);
        check("R1 reset done", done, 1'b0);
        check("R1 reset failed", failed, 1'b0);

        // R3: already idle -> skip
        idle = 1'b1; tick(3);
        pulse_start();
        check("R3 skip done pulse", done, 1'b1);
        check("R3 skip no halt_req", req, 1'b0);
        tick(1);
        check("R3 done single cycle", done, 1'b0);

        // R2/R4/R6: ack path, port becomes idle
        idle = 1'b0; tick(3);
        pulse_start();
        check("R4 halt_req raised", req, 1'b1);
        tick(4);
        idle = 1'b1; ack = 1'b1;
        tick(3);
        check("R2 two-stage latency keeps halt_req", req, 1'b1);
        tick(1);
        check("R6 halt_req dropped", req, 1'b0);
        check("R6 done pulse", done, 1'b1);
        check("R6 not failed when idle", failed, 1'b0);
        ack = 1'b0; tick(4);

        // R6/R8: acknowledged but still busy -> failure, held
        idle = 1'b0; tick(3);
        pulse_start();
        tick(2);
        ack = 1'b1; tick(4);
        check("R6 failed set when busy", failed, 1'b1);
        ack = 1'b0; tick(8);
        check("R8 failed held", failed, 1'b1);
        idle = 1'b1; tick(3);
        pulse_start();
        check("R8 failed cleared by start", failed, 1'b0);
        tick(2);

        // R5/R9: timeout while busy, stray start ignored
        idle = 1'b0; tick(3);
        pulse_start();
        high_cnt = 1;
        tick(3);
        pulse_start();
        high_cnt += 4;
        check("R9 start ignored while busy", req, 1'b1);
        while (req) begin tick(1); if (req) high_cnt++; end
        check("R5 timeout length", (high_cnt == LIMIT + 2), 1'b1);
        if (high_cnt != LIMIT + 2)
            $display("FAIL R5 halt_req cycles actual=%0d expected=%0d", high_cnt, LIMIT + 2);
        check("R6 failed after timeout busy", failed, 1'b1);
        tick(2);

        // R7: timeout, but port went idle during the wait
        pulse_start();
        tick(6);
        idle = 1'b1;
        while (req) tick(1);
        check("R7 timeout with idle not failed", failed, 1'b0);
        check("R7 done at timeout end", done, 1'b1);
        tick(3);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule